// File: doc/BRIEF.md
# I2C SCL period generator

This block sets the length of the two SCL phases for an I2C master. A prescaler divides the system clock by a power of two, from 1 to 128, and its output is the reference tick. A low-phase count and a high-phase count, each 5 bits wide, set how many reference ticks each phase lasts. Each phase also gets a fixed number of extra ticks. This overhead covers the delay of the input synchroniser and of the noise filter. It is 4 ticks when the divider is 1 and 3 ticks for every other divider.

The generator pulls SCL low for the low phase and then releases it. The high phase does not start counting when SCL is released. It starts only when the synchronised and filtered SCL line actually reads high. A device that holds SCL low (clock stretching) therefore lengthens the high phase, and so does a slow rising edge. The transfer engine receives a one-cycle strobe when each phase begins. The divider field can only be loaded when the unlock qualifier is set in the same write.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, and whenever `enable` is low or `soft_reset` is high, SCL is released (`scl_drive_low`=0) and no strobe is issued. The state change is registered and is visible one clock after the control input is sampled.
- R2: With divider select 0 (divide by 1), the low phase lasts exactly (low_period + 4) clock cycles.
- R3: With divider select n ≠ 0, a phase lasts exactly (period + 3) × 2^n clock cycles.
- R4: The high phase lasts exactly (high_period + overhead) × 2^n clock cycles. It is counted from the cycle in which `strobe_high_begin` is high up to the cycle before `scl_drive_low` rises again.
- R5: After release, the high phase begins only once the filtered SCL input reads high. While another device holds SCL low, `scl_drive_low` stays 0 and `strobe_high_begin` stays 0. Once the line goes high, the high phase keeps its full length.
- R6: A high pulse on `scl_in` that lasts a single clock cycle is filtered out and does not start the high phase.
- R7: A write with `mode_wr`=1 loads `mode_psc` into the divider select only when `mode_unlock`=1 in the same cycle. Without the unlock, the divider select is unchanged. After reset the divider select is 0.
- R8: A period value of 0 is treated as 1.
- R9: `strobe_low_begin` is a one-cycle pulse in the first cycle in which `scl_drive_low` is 1. `strobe_high_begin` is a one-cycle pulse in the first counted high cycle, with SCL released.
- R10: When the generator leaves the stopped state (`enable`=1 and `soft_reset`=0), it starts with a low phase in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; low stops counting and releases SCL |
| soft_reset | input | 1 | Synchronous stop of the phase sequencer |
| mode_wr | input | 1 | Write strobe for the divider select |
| mode_unlock | input | 1 | Qualifier that must be 1 in the same write for the load to take effect |
| mode_psc | input | 3 | Divider select n (divide by 2^n) |
| high_period | input | 5 | High-phase tick count (0 is treated as 1) |
| low_period | input | 5 | Low-phase tick count (0 is treated as 1) |
| scl_in | input | 1 | Sampled SCL bus level (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| strobe_low_begin | output | 1 | One-cycle pulse at the start of a low phase |
| strobe_high_begin | output | 1 | One-cycle pulse at the start of a counted high phase |

## Verification
A stop request (`soft_reset`) can land in the same cycle as the terminal tick of a low phase. In that cycle the sequencer would otherwise release SCL and enter the wait for a high line. The bench provokes this case by raising `soft_reset` in exactly the last low cycle. It then requires that SCL is released, that no high-phase strobe follows, and that a fresh low phase with its strobe begins in the cycle after the stop is lifted. A single-cycle release inside a stretched wait is also covered, because the filter and the phase-start decision meet there.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

    // Phase sequencer states
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

endpackage

// File: rtl/sclg_prescale.sv
// Reference tick generator: one tick every 2^psc clock cycles,
// realigned to zero whenever restart is asserted.
module sclg_prescale #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    input  logic             restart,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = (DIV_W'(1) << psc) - DIV_W'(1);
        tick  = (div_q == mask);
        div_d = div_q + DIV_W'(1);
        if (restart || tick) begin
            div_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/sclg_line_filter.sv
// SCL input conditioning: multi-flop synchroniser followed by a filter
// that only accepts a level seen on two consecutive cycles.
module sclg_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   hold_d, hold_q;
    logic                   filt_d, filt_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            assign sync_d = {sync_q[SYNC_STAGES-2:0], line_in};
        end else begin : g_single
            assign sync_d = line_in;
        end
    endgenerate

    always_comb begin
        hold_d = sync_q[SYNC_STAGES-1];
        filt_d = (sync_q[SYNC_STAGES-1] == hold_q) ? hold_q : filt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hold_q <= 1'b1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            hold_q <= hold_d;
            filt_q <= filt_d;
        end
    end

    assign line_out = filt_q;

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import sclg_pkg::*;
#(
    parameter int PSC_W       = 3,
    parameter int PER_W       = 5,
    parameter int OVH_UNDIV   = 4,
    parameter int OVH_DIV     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             soft_reset,
    input  logic             mode_wr,
    input  logic             mode_unlock,
    input  logic [PSC_W-1:0] mode_psc,
    input  logic [PER_W-1:0] high_period,
    input  logic [PER_W-1:0] low_period,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             strobe_low_begin,
    output logic             strobe_high_begin
);
    // One extra bit covers period plus overhead (overheads are small)
    localparam int CNT_W = PER_W + 1;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [PSC_W-1:0] psc;
        logic             drive;
        logic             lo_stb;
        logic             hi_stb;
    } gen_state_t;

    gen_state_t r_d, r_q;

    logic             tick;
    logic             restart;
    logic             line_hi;
    logic             run;
    logic [PER_W-1:0] hi_val, lo_val;
    logic [CNT_W-1:0] ovh, hi_len, lo_len;

    sclg_prescale #(.PSC_W(PSC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .psc    (r_q.psc),
        .restart(restart),
        .tick   (tick)
    );

    sclg_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (scl_in),
        .line_out(line_hi)
    );

    always_comb begin
        r_d        = r_q;
        r_d.lo_stb = 1'b0;
        r_d.hi_stb = 1'b0;
        restart    = 1'b0;
        run        = enable && !soft_reset;

        if (mode_wr && mode_unlock) begin
            r_d.psc = mode_psc;
        end

        ovh    = (r_q.psc == '0) ? CNT_W'(OVH_UNDIV) : CNT_W'(OVH_DIV);
        hi_val = (high_period == '0) ? PER_W'(1) : high_period;
        lo_val = (low_period  == '0) ? PER_W'(1) : low_period;
        hi_len = CNT_W'(hi_val) + ovh;
        lo_len = CNT_W'(lo_val) + ovh;

        unique case (r_q.ph)
            PH_IDLE: begin
                restart    = 1'b1;
                r_d.ph     = PH_LOW;
                r_d.cnt    = '0;
                r_d.lo_stb = 1'b1;
            end
            PH_LOW: begin
                if (tick) begin
                    if (r_q.cnt == lo_len - CNT_W'(1)) begin
                        r_d.ph  = PH_WAIT;
                        r_d.cnt = '0;
                        restart = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            PH_WAIT: begin
                restart = 1'b1;
                if (line_hi) begin
                    r_d.ph     = PH_HIGH;
                    r_d.cnt    = '0;
                    r_d.hi_stb = 1'b1;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    if (r_q.cnt == hi_len - CNT_W'(1)) begin
                        r_d.ph     = PH_LOW;
                        r_d.cnt    = '0;
                        r_d.lo_stb = 1'b1;
                        restart    = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                r_d.ph = PH_IDLE;
            end
        endcase

        if (!run) begin
            r_d.ph     = PH_IDLE;
            r_d.cnt    = '0;
            r_d.lo_stb = 1'b0;
            r_d.hi_stb = 1'b0;
            restart    = 1'b1;
        end

        r_d.drive = (r_d.ph == PH_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, cnt: '0, psc: '0, drive: 1'b0,
                     lo_stb: 1'b0, hi_stb: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_drive_low     = r_q.drive;
    assign strobe_low_begin  = r_q.lo_stb;
    assign strobe_high_begin = r_q.hi_stb;

endmodule

// File: rtl/sclg_checker.sv
module sclg_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic soft_reset,
    input logic scl_drive_low,
    input logic strobe_low_begin,
    input logic strobe_high_begin,
    input logic line_hi
);

    p_release_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || soft_reset) |=> (!scl_drive_low && !strobe_low_begin && !strobe_high_begin));

    p_low_strobe_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low_begin |-> scl_drive_low);

    p_high_strobe_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_high_begin |-> !scl_drive_low);

    p_drive_rise_strobed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> strobe_low_begin);

    p_low_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low_begin |=> !strobe_low_begin);

    p_high_needs_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_high_begin |-> $past(line_hi));

    p_no_instant_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> !strobe_high_begin);

endmodule

bind scl_period_gen sclg_checker u_sclg_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .enable           (enable),
    .soft_reset       (soft_reset),
    .scl_drive_low    (scl_drive_low),
    .strobe_low_begin (strobe_low_begin),
    .strobe_high_begin(strobe_high_begin),
    .line_hi          (line_hi)
);

// File: tb/tb_scl_period_gen.sv
module tb_scl_period_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       soft_reset = 1'b0;
    logic       mode_wr = 1'b0;
    logic       mode_unlock = 1'b0;
    logic [2:0] mode_psc = 3'd0;
    logic [4:0] high_period = 5'd1;
    logic [4:0] low_period = 5'd1;
    logic       hold_low = 1'b0;
    logic       scl_in;
    logic       scl_drive_low;
    logic       strobe_low_begin;
    logic       strobe_high_begin;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Open-drain bus: released line pulls up unless someone holds it low
    assign scl_in = ~(scl_drive_low | hold_low);

    scl_period_gen dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .enable           (enable),
        .soft_reset       (soft_reset),
        .mode_wr          (mode_wr),
        .mode_unlock      (mode_unlock),
        .mode_psc         (mode_psc),
        .high_period      (high_period),
        .low_period       (low_period),
        .scl_in           (scl_in),
        .scl_drive_low    (scl_drive_low),
        .strobe_low_begin (strobe_low_begin),
        .strobe_high_begin(strobe_high_begin)
    );

    typedef struct packed {
        logic [2:0]  psc;
        logic [4:0]  lo;
        logic [4:0]  hi;
        logic [15:0] exp_lo;
        logic [15:0] exp_hi;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 5'd1,  5'd1,  16'd5,   16'd5},
        '{3'd0, 5'd7,  5'd31, 16'd11,  16'd35},
        '{3'd1, 5'd5,  5'd3,  16'd16,  16'd12},
        '{3'd3, 5'd4,  5'd2,  16'd56,  16'd40},
        '{3'd7, 5'd1,  5'd1,  16'd512, 16'd512},
        '{3'd2, 5'd31, 5'd31, 16'd136, 16'd136}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic unlock, input logic [2:0] p);
        @(negedge clk);
        mode_wr     = 1'b1;
        mode_unlock = unlock;
        mode_psc    = p;
        @(negedge clk);
        mode_wr     = 1'b0;
        mode_unlock = 1'b0;
    endtask

    task automatic measure_low(output int n);
        do @(negedge clk); while (!strobe_low_begin);
        n = 0;
        while (scl_drive_low) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_high(output int n);
        while (!strobe_high_begin) @(negedge clk);
        n = 0;
        while (!scl_drive_low) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        int stb_cnt;
        int drv_cnt;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset drive", int'(scl_drive_low), 0);
        chk("R1 reset strobe", int'(strobe_low_begin | strobe_high_begin), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 disabled drive", int'(scl_drive_low), 0);

        // R2 R3 R4: vector table
        for (int i = 0; i < NVEC; i++) begin
            enable = 1'b0;
            write_mode(1'b1, VECS[i].psc);
            low_period  = VECS[i].lo;
            high_period = VECS[i].hi;
            @(negedge clk);
            enable = 1'b1;
            measure_low(w);
            chk((VECS[i].psc == 3'd0) ? "R2 low width" : "R3 low width", w, int'(VECS[i].exp_lo));
            measure_high(w);
            chk("R4 high width", w, int'(VECS[i].exp_hi));
            @(negedge clk);
            enable = 1'b0;
        end

        // R10 R9: first phase after enable is low, strobe is one cycle
        write_mode(1'b1, 3'd0);
        low_period  = 5'd3;
        high_period = 5'd3;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk("R10 first phase low", int'(scl_drive_low), 1);
        chk("R9 low strobe start", int'(strobe_low_begin), 1);
        @(negedge clk);
        chk("R9 low strobe single", int'(strobe_low_begin), 0);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 disable releases", int'(scl_drive_low), 0);

        // R8: zero period treated as one
        low_period  = 5'd0;
        high_period = 5'd0;
        @(negedge clk);
        enable = 1'b1;
        measure_low(w);
        chk("R8 zero low", w, 5);
        measure_high(w);
        chk("R8 zero high", w, 5);
        @(negedge clk);
        enable = 1'b0;

        // R7: divider load needs the unlock qualifier
        low_period  = 5'd4;
        high_period = 5'd4;
        write_mode(1'b0, 3'd3);
        @(negedge clk);
        enable = 1'b1;
        measure_low(w);
        chk("R7 locked write ignored", w, 8);
        @(negedge clk);
        enable = 1'b0;
        write_mode(1'b1, 3'd2);
        @(negedge clk);
        enable = 1'b1;
        measure_low(w);
        chk("R7 unlocked write applied", w, 28);
        @(negedge clk);
        enable = 1'b0;

        // R5 R6: clock stretching with a one-cycle glitch
        write_mode(1'b1, 3'd0);
        low_period  = 5'd2;
        high_period = 5'd2;
        @(negedge clk);
        enable = 1'b1;
        do @(negedge clk); while (!strobe_low_begin);
        hold_low = 1'b1;
        while (scl_drive_low) @(negedge clk);
        stb_cnt = 0;
        drv_cnt = 0;
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            stb_cnt += int'(strobe_high_begin);
            drv_cnt += int'(scl_drive_low);
        end
        chk("R5 no high strobe while held", stb_cnt, 0);
        chk("R5 released while held", drv_cnt, 0);
        hold_low = 1'b0;
        @(negedge clk);
        hold_low = 1'b1;
        stb_cnt = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            stb_cnt += int'(strobe_high_begin | scl_drive_low);
        end
        chk("R6 glitch ignored", stb_cnt, 0);
        hold_low = 1'b0;
        measure_high(w);
        chk("R5 full high after stretch", w, 6);
        @(negedge clk);
        enable = 1'b0;

        // R1 R10: stop lands on the terminal low cycle
        low_period = 5'd1;
        @(negedge clk);
        enable = 1'b1;
        do @(negedge clk); while (!strobe_low_begin);
        repeat (4) @(negedge clk);
        soft_reset = 1'b1;
        @(negedge clk);
        chk("R1 soft reset releases", int'(scl_drive_low), 0);
        stb_cnt = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            stb_cnt += int'(strobe_high_begin | strobe_low_begin | scl_drive_low);
        end
        chk("R1 quiet during soft reset", stb_cnt, 0);
        soft_reset = 1'b0;
        @(negedge clk);
        chk("R10 restart with low strobe", int'(strobe_low_begin), 1);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule